// File: doc/BRIEF.md
# Packed SIMD Logical Right Shifter

This unit shifts a 64-bit operand to the right with zero fill, treating it as four 16-bit lanes, two 32-bit lanes or one 64-bit lane. Every lane moves by the same unsigned count. The count comes from one of two places: a full 64-bit register-style operand, or an 8-bit immediate that is zero-extended. If the count is larger than the lane width minus one, the whole result is zero. The over-range test looks at every bit of the count, so a large register count is never cut down to its low bits.

A request is one cycle with `valid_i` high. On that cycle the unit also receives:
- the second opcode byte that follows the escape byte;
- the reg field of the ModRM byte;
- a flag that says which count source to use.

The unit decodes the lane size and the operand form from the opcode byte. It checks the sub-opcode of the immediate forms. One clock later it either registers the shifted value and pulses `done_o`, or it pulses `illegal_o` and leaves the result register as it was.

Top module: `psrl_unit`

## Requirements
- R1: When the opcode byte is 0xD1 or 0x71 (word mode), each of the four 16-bit lanes is shifted right by the count, and each lane's vacated high bits are zero.
- R2: When the opcode byte is 0xD2 or 0x72 (doubleword mode), each of the two 32-bit lanes is shifted right by the count, and each lane's vacated high bits are zero.
- R3: When the opcode byte is 0xD3 or 0x73 (quadword mode), the whole 64-bit value is shifted right by the count, and the vacated high bits are zero.
- R4: If the count is above 15 in word mode, above 31 in doubleword mode, or above 63 in quadword mode, the entire result is zero. This test compares all 64 bits of a register count, so 0x1_0000_0000 gives zero.
- R5: When `imm_sel_i` = 1, the count is `count_imm_i` zero-extended to 64 bits, and the R4 test is applied to that value. When `imm_sel_i` = 0, the count is `count_reg_i`.
- R6: The register-count forms are opcode bytes 0xD1, 0xD2 and 0xD3. They are legal only with `imm_sel_i` = 0, and they ignore `modrm_reg_i`.
- R7: The immediate-count forms are opcode bytes 0x71, 0x72 and 0x73. They are legal only with `imm_sel_i` = 1 and `modrm_reg_i` = 2. Any other reg value raises `illegal_o`, and the result register keeps its value.
- R8: A request with any other opcode byte, or with a source flag that does not match the form, raises `illegal_o`. It produces no `done_o`, and the result register keeps its value.
- R9: The result register and `done_o` update on the clock edge that samples a legal valid request. `done_o` is a one-cycle pulse per request. With no request, neither `done_o` nor `illegal_o` rises.
- R10: A count of zero returns the destination value unchanged in every lane mode.
- R11: After a synchronous active-low reset, `result_o` is zero, and `done_o` and `illegal_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| valid_i | input | 1 | Request strobe, one operation per high cycle |
| op_byte_i | input | 8 | Second opcode byte after the escape byte |
| modrm_reg_i | input | 3 | Reg field of the ModRM byte |
| imm_sel_i | input | 1 | 1 selects the immediate count, 0 the register count |
| dest_i | input | 64 | Value to be shifted |
| count_reg_i | input | 64 | Register-style shift count |
| count_imm_i | input | 8 | Immediate shift count |
| result_o | output | 64 | Registered shifted value |
| done_o | output | 1 | One-cycle pulse when a legal result is written |
| illegal_o | output | 1 | One-cycle pulse for a rejected request |

## Verification
The assertions assume three things about the inputs:
- every input is stable around the sampling edge;
- `valid_i` is low throughout reset;
- the reset holds for at least one edge.

Given those, the only relation between successive requests that the assertions rely on is that each result depends on nothing but the inputs of its own cycle. The stimulus drives all inputs on the falling edge and holds `valid_i` high for exactly one cycle per request. It drops `valid_i` between requests, so the pulse shape of `done_o` can be observed. The sweeps cover:
- every lane mode with counts from 0 through 70, on several data patterns, through both count sources;
- register counts whose upper bits alone push them out of range;
- every reg field value for the immediate forms;
- unknown opcode bytes and mismatched source flags.

// File: rtl/psrl_pkg.sv
// Package: shared widths and the lane-mode type of the packed shifter.
// Assumes a 64-bit datapath split into lanes of 16, 32 or 64 bits.
package psrl_pkg;

    localparam int DATA_W  = 64;
    localparam int IMM_W   = 8;
    localparam int SHIFT_W = $clog2(DATA_W);

    typedef enum logic [1:0] {
        LANE_W16 = 2'd0,
        LANE_W32 = 2'd1,
        LANE_W64 = 2'd2
    } lane_mode_e;

    // Width in bits of one lane for a mode.
    function automatic int lane_bits(lane_mode_e m);
        case (m)
            LANE_W16: return 16;
            LANE_W32: return 32;
            default:  return 64;
        endcase
    endfunction

endpackage

// File: rtl/psrl_decode.sv
// Module: opcode decoder.
// Maps the second opcode byte to a lane mode and an operand form.
// Checks the sub-opcode of the immediate forms and that the source flag agrees
// with the form. Purely combinational.
// Assumes the escape byte was already matched upstream.
module psrl_decode
    import psrl_pkg::*;
#(
    parameter logic [7:0] REG_BASE = 8'hD0,
    parameter logic [7:0] IMM_BASE = 8'h70,
    parameter logic [2:0] IMM_SUB  = 3'd2
) (
    input  logic [7:0]  op_byte_i,
    input  logic [2:0]  modrm_reg_i,
    input  logic        imm_sel_i,
    output lane_mode_e  mode_o,
    output logic        legal_o
);

    logic       known;
    logic       is_imm;
    logic [1:0] low_code;

    // Classify the byte as register form, immediate form or unknown.
    always_comb begin
        known    = 1'b0;
        is_imm   = 1'b0;
        low_code = op_byte_i[1:0];
        if (op_byte_i[7:2] == REG_BASE[7:2] && low_code != 2'd0) begin
            known = 1'b1;
        end else if (op_byte_i[7:2] == IMM_BASE[7:2] && low_code != 2'd0) begin
            known  = 1'b1;
            is_imm = 1'b1;
        end
    end

    // Lane size comes from the low two bits: 1 word, 2 doubleword, 3 quadword.
    always_comb begin
        case (low_code)
            2'd1:    mode_o = LANE_W16;
            2'd2:    mode_o = LANE_W32;
            default: mode_o = LANE_W64;
        endcase
    end

    // Legal when the form is known, the source agrees and the sub-opcode fits.
    always_comb begin
        legal_o = known && (is_imm == imm_sel_i) &&
                  (!is_imm || modrm_reg_i == IMM_SUB);
    end

endmodule

// File: rtl/psrl_count.sv
// Module: count selection and range test.
// Widens the chosen count to the full data width and compares it with the
// largest shift the lane mode allows. Returns the low shift bits, an
// over-range flag and a zero-count flag. Purely combinational.
module psrl_count
    import psrl_pkg::*;
#(
    parameter int CW = DATA_W,
    parameter int IW = IMM_W,
    parameter int SW = SHIFT_W
) (
    input  logic [CW-1:0] count_reg_i,
    input  logic [IW-1:0] count_imm_i,
    input  logic          imm_sel_i,
    input  lane_mode_e    mode_i,
    output logic [SW-1:0] shift_o,
    output logic          over_o,
    output logic          zero_cnt_o
);

    logic [CW-1:0] eff_cnt;
    logic [CW-1:0] max_cnt;

    // Zero-extend the immediate or pass the register count.
    always_comb begin
        eff_cnt = imm_sel_i ? {{(CW-IW){1'b0}}, count_imm_i} : count_reg_i;
    end

    // Largest permitted count for the lane mode.
    always_comb begin
        max_cnt = CW'(lane_bits(mode_i) - 1);
    end

    // Full-width comparison, low bits taken as the shift amount.
    always_comb begin
        over_o     = eff_cnt > max_cnt;
        shift_o    = eff_cnt[SW-1:0];
        zero_cnt_o = eff_cnt == '0;
    end

    // a_r4_shift_in_lane: when in range, the shift fits inside the lane.
    always_comb begin
        if (!over_o) begin
            a_r4_shift_in_lane: assert (int'(shift_o) < lane_bits(mode_i));
        end
    end

endmodule

// File: rtl/psrl_lanes.sv
// Module: lane-split shifter.
// Shifts the whole word once, then clears every bit that crossed a lane
// boundary. The whole result is forced to zero when the count is out of range.
// Assumes shift_i is below the lane width whenever zero_i is low.
module psrl_lanes
    import psrl_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int SW = SHIFT_W
) (
    input  logic [W-1:0]  data_i,
    input  logic [SW-1:0] shift_i,
    input  lane_mode_e    mode_i,
    input  logic          zero_i,
    output logic [W-1:0]  data_o
);

    localparam int PW = SW + 1;

    logic [W-1:0] shifted;
    logic [W-1:0] keep;

    // One full-width logical shift shared by all lane modes.
    always_comb begin
        shifted = data_i >> shift_i;
    end

    // Per bit: keep it if its lane position plus the shift stays in the lane.
    for (genvar gi = 0; gi < W; gi++) begin : g_bit
        localparam int P16 = gi % 16;
        localparam int P32 = gi % 32;
        localparam int P64 = gi;
        always_comb begin
            case (mode_i)
                LANE_W16: keep[gi] = (PW'(P16) + PW'(shift_i)) < PW'(16);
                LANE_W32: keep[gi] = (PW'(P32) + PW'(shift_i)) < PW'(32);
                default:  keep[gi] = (PW'(P64) + PW'(shift_i)) < PW'(W);
            endcase
        end
    end

    // Apply the lane mask or the over-range clear.
    always_comb begin
        data_o = zero_i ? '0 : (shifted & keep);
    end

    // a_r1_top_bits_clear: a nonzero word shift clears the top bit of each lane.
    always_comb begin
        if (mode_i == LANE_W16 && shift_i != '0) begin
            a_r1_top_bits_clear: assert (data_o[15] == 1'b0 && data_o[31] == 1'b0 &&
                                         data_o[47] == 1'b0 && data_o[63] == 1'b0);
        end
    end

    // a_r2_top_bits_clear: a nonzero doubleword shift clears each lane's top bit.
    always_comb begin
        if (mode_i == LANE_W32 && shift_i != '0) begin
            a_r2_top_bits_clear: assert (data_o[31] == 1'b0 && data_o[63] == 1'b0);
        end
    end

endmodule

// File: rtl/psrl_unit.sv
// Module: top of the packed logical right shifter.
// Decodes a request, shifts in one cycle and registers the result with a done
// or illegal pulse. Assumes every request is a single valid_i cycle.
// Reset is synchronous, active low.
module psrl_unit
    import psrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic [7:0]        op_byte_i,
    input  logic [2:0]        modrm_reg_i,
    input  logic              imm_sel_i,
    input  logic [DATA_W-1:0] dest_i,
    input  logic [DATA_W-1:0] count_reg_i,
    input  logic [IMM_W-1:0]  count_imm_i,
    output logic [DATA_W-1:0] result_o,
    output logic              done_o,
    output logic              illegal_o
);

    lane_mode_e         mode;
    logic               legal;
    logic [SHIFT_W-1:0] shift_amt;
    logic               over;
    logic               zero_cnt;
    logic [DATA_W-1:0]  shifted;
    logic [DATA_W-1:0]  result_q;
    logic               done_q;
    logic               illegal_q;

    psrl_decode u_decode (
        .op_byte_i   (op_byte_i),
        .modrm_reg_i (modrm_reg_i),
        .imm_sel_i   (imm_sel_i),
        .mode_o      (mode),
        .legal_o     (legal)
    );

    psrl_count u_count (
        .count_reg_i (count_reg_i),
        .count_imm_i (count_imm_i),
        .imm_sel_i   (imm_sel_i),
        .mode_i      (mode),
        .shift_o     (shift_amt),
        .over_o      (over),
        .zero_cnt_o  (zero_cnt)
    );

    psrl_lanes u_lanes (
        .data_i  (dest_i),
        .shift_i (shift_amt),
        .mode_i  (mode),
        .zero_i  (over),
        .data_o  (shifted)
    );

    // Result register: written only by a legal request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q <= '0;
        end else if (valid_i && legal) begin
            result_q <= shifted;
        end
    end

    // Completion strobes: one cycle per request, legal or rejected.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q    <= 1'b0;
            illegal_q <= 1'b0;
        end else begin
            done_q    <= valid_i && legal;
            illegal_q <= valid_i && !legal;
        end
    end

    assign result_o  = result_q;
    assign done_o    = done_q;
    assign illegal_o = illegal_q;

    // a_r9_done_follows: a legal request is answered one cycle later.
    a_r9_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i && legal |=> done_o);

    // a_r9_quiet_idle: no request, no strobe.
    a_r9_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> !done_o && !illegal_o);

    // a_r8_exclusive: a request is never both accepted and rejected.
    a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && illegal_o));

    // a_r7_hold_on_reject: a rejected request leaves the result untouched.
    a_r7_hold_on_reject: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> $stable(result_o));

    // a_r10_zero_passthrough: a zero count returns the destination.
    a_r10_zero_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i && legal && zero_cnt |=> result_o == $past(dest_i));

    // a_r4_over_clears: an out-of-range count yields zero.
    a_r4_over_clears: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i && legal && over |=> result_o == '0);

endmodule

// File: tb/psrl_unit_test.sv
// Bench: sweeps lane modes, counts, count sources and opcode encodings, and
// compares against an arithmetic model of per-lane logical right shifts.
module psrl_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic [7:0]  op_byte_i = '0;
    logic [2:0]  modrm_reg_i = '0;
    logic        imm_sel_i = 1'b0;
    logic [63:0] dest_i = '0;
    logic [63:0] count_reg_i = '0;
    logic [7:0]  count_imm_i = '0;
    logic [63:0] result_o;
    logic        done_o;
    logic        illegal_o;

    int checks = 0;
    int fails = 0;
    logic [63:0] last_res = '0;
    bit finished = 1'b0;

    psrl_unit uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .valid_i     (valid_i),
        .op_byte_i   (op_byte_i),
        .modrm_reg_i (modrm_reg_i),
        .imm_sel_i   (imm_sel_i),
        .dest_i      (dest_i),
        .count_reg_i (count_reg_i),
        .count_imm_i (count_imm_i),
        .result_o    (result_o),
        .done_o      (done_o),
        .illegal_o   (illegal_o)
    );

    always #5 clk = ~clk;

    // Record one comparison.
    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Model: per-lane logical right shift, whole result zero if over range.
    function automatic logic [63:0] model(input int w, input logic [63:0] d,
                                          input logic [63:0] c);
        logic [63:0] m;
        logic [63:0] r;
        logic [63:0] lane;
        if (c > 64'(w - 1)) return 64'd0;
        m = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
        r = '0;
        for (int l = 0; l < 64 / w; l++) begin
            lane = (d >> (l * w)) & m;
            lane = lane >> c;
            r = r | (lane << (l * w));
        end
        return r;
    endfunction

    // Issue one request, then check the response and the pulse end.
    task automatic run_op(input string req, input logic [7:0] ob, input logic [2:0] rg,
                          input logic isel, input logic [63:0] d,
                          input logic [63:0] creg, input logic [7:0] cimm,
                          input bit exp_legal, input logic [63:0] exp_res);
        @(negedge clk);
        valid_i = 1'b1; op_byte_i = ob; modrm_reg_i = rg; imm_sel_i = isel;
        dest_i = d; count_reg_i = creg; count_imm_i = cimm;
        @(negedge clk);
        valid_i = 1'b0;
        chk({req, " done"}, 64'(done_o), 64'(exp_legal));
        chk({req, " illegal"}, 64'(illegal_o), 64'(!exp_legal));
        if (exp_legal) last_res = exp_res;
        chk({req, " result"}, result_o, last_res);
        @(negedge clk);
        chk("R9 pulse end", 64'({done_o, illegal_o}), 64'd0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [63:0] pats [4];
        string tag;
        int w;
        pats[0] = 64'hFFFC_11C7_FFFC_11C7;
        pats[1] = 64'hFFFF_FFFF_FFFF_FFFF;
        pats[2] = 64'h8001_8001_8001_8001;
        pats[3] = 64'hDEAD_BEEF_0123_4567;

        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11 result", result_o, 64'd0);
        chk("R11 strobes", 64'({done_o, illegal_o}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 idle", 64'({done_o, illegal_o}), 64'd0);

        // Worked example: 0xFFFC >> 2 = 0x3FFF, 0x11C7 >> 2 = 0x0471 (R1)
        run_op("R1 example", 8'hD1, 3'd0, 1'b0, pats[0], 64'd2, 8'd0, 1'b1,
               64'h3FFF_0471_3FFF_0471);

        // R1 R2 R3 R5 R6 R10 R4: sweep modes, counts and sources.
        for (int md = 1; md <= 3; md++) begin
            w = (md == 1) ? 16 : (md == 2) ? 32 : 64;
            tag = (md == 1) ? "R1" : (md == 2) ? "R2" : "R3";
            for (int p = 0; p < 4; p++) begin
                for (int c = 0; c <= 70; c++) begin
                    run_op({tag, " R6 reg"}, 8'hD0 + 8'(md), 3'(c), 1'b0, pats[p],
                           64'(c), 8'hFF, 1'b1, model(w, pats[p], 64'(c)));
                    run_op({tag, " R5 imm"}, 8'h70 + 8'(md), 3'd2, 1'b1, pats[p],
                           64'hFFFF, 8'(c), 1'b1, model(w, pats[p], 64'(c)));
                end
                run_op("R10 zero count", 8'hD0 + 8'(md), 3'd0, 1'b0, pats[p],
                       64'd0, 8'd5, 1'b1, pats[p]);
                run_op("R5 imm 255", 8'h70 + 8'(md), 3'd2, 1'b1, pats[p],
                       64'd0, 8'hFF, 1'b1, 64'd0);
                run_op("R4 high count", 8'hD0 + 8'(md), 3'd0, 1'b0, pats[p],
                       64'h1_0000_0000, 8'd0, 1'b1, 64'd0);
                run_op("R4 top bit", 8'hD0 + 8'(md), 3'd0, 1'b0, pats[p],
                       64'h8000_0000_0000_0001, 8'd0, 1'b1, 64'd0);
                run_op("R4 bit 8", 8'hD0 + 8'(md), 3'd0, 1'b0, pats[p],
                       64'h101, 8'd1, 1'b1, 64'd0);
            end
        end

        // R7: every reg field on the immediate forms.
        run_op("R7 seed", 8'hD3, 3'd0, 1'b0, pats[3], 64'd4, 8'd0, 1'b1,
               model(64, pats[3], 64'd4));
        for (int md = 1; md <= 3; md++) begin
            for (int rg = 0; rg < 8; rg++) begin
                w = (md == 1) ? 16 : (md == 2) ? 32 : 64;
                run_op("R7 subop", 8'h70 + 8'(md), 3'(rg), 1'b1, pats[1], 64'd0,
                       8'd3, rg == 2, model(w, pats[1], 64'd3));
            end
        end

        // R8: source mismatch and unknown bytes.
        run_op("R8 reg form imm flag", 8'hD2, 3'd2, 1'b1, pats[1], 64'd1, 8'd1,
               1'b0, 64'd0);
        run_op("R8 imm form reg flag", 8'h72, 3'd2, 1'b0, pats[1], 64'd1, 8'd1,
               1'b0, 64'd0);
        for (int b = 0; b < 256; b++) begin
            if (!((b >= 8'hD1 && b <= 8'hD3) || (b >= 8'h71 && b <= 8'h73))) begin
                run_op("R8 unknown", 8'(b), 3'd2, 1'(b & 1), pats[2], 64'd1,
                       8'd1, 1'b0, 64'd0);
            end
        end

        // R9: back-to-back requests each produce a pulse.
        @(negedge clk);
        valid_i = 1'b1; op_byte_i = 8'hD1; imm_sel_i = 1'b0;
        dest_i = pats[1]; count_reg_i = 64'd4;
        @(negedge clk);
        chk("R9 first", result_o, model(16, pats[1], 64'd4));
        chk("R9 first done", 64'(done_o), 64'd1);
        count_reg_i = 64'd8;
        @(negedge clk);
        valid_i = 1'b0;
        chk("R9 second", result_o, model(16, pats[1], 64'd8));
        chk("R9 second done", 64'(done_o), 64'd1);
        @(negedge clk);
        chk("R9 released", 64'(done_o), 64'd0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule